// File: doc/BRIEF.md
# Maskable Latched Interrupt Controller

This block gathers up to 32 interrupt inputs into one request line toward a processor. Each input is either edge-style or level-style, fixed per source at build time. A status register records pending requests, and a mask register holds one enable bit per source. The CPU request is raised when some pending bit has its enable bit set and the processor's global interrupt-enable input is high. Software reaches both registers through a simple register read/write port. Address 0 selects the mask and address 1 selects the status. Bit n of either register belongs to source n, so software finds pending sources by scanning the status word upward from bit 0.

A build-time parameter picks the acknowledge rule. In the standard rule, a status write clears each bit written as 1 and leaves bits written as 0 alone. In status, level-style sources simply mirror their synchronized input. In the inverted rule, a status write clears each bit written as 0 and leaves bits written as 1 alone, so software acknowledges by read-modify-writing the bit to zero. In this rule, level-style sources are captured like edges and stay pending until cleared.

Every input passes through a two-flop synchronizer before it is used. A source's status bit therefore changes on the third rising clock edge after the input changes. The CPU request is registered and follows one edge after that.

Top module: `irq_latch_ctrl`

## Requirements
- R1: While reset is asserted, the mask register, the status register and `cpu_irq` are all zero.
- R2: A write with `reg_addr`=0 loads the mask from `reg_wdata` on the next clock edge. Reading with `reg_addr`=0 returns the mask.
- R3: For an edge-style source, a low-to-high input change sets status bit n on the third rising edge after the change. The bit stays set after the input falls, until it is acknowledged.
- R4: In the standard rule (ACK_ZERO_CLR=0), a write with `reg_addr`=1 clears each edge-style status bit whose `reg_wdata` bit is 1. Bits written 0 are unchanged.
- R5: In the standard rule, a level-style status bit equals that input delayed by the synchronizer, which is three clock edges. Writes to status have no effect on it.
- R6: In the inverted rule (ACK_ZERO_CLR=1), a status write clears each status bit whose `reg_wdata` bit is 0. Bits written 1 are unchanged.
- R7: In the inverted rule, a level-style source is latched. Its bit stays set after the input falls. Its bit cannot be cleared while the synchronized input is still high.
- R8: If a new set event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: On each clock edge, `cpu_irq` becomes the OR over n of (status[n] AND mask[n]), ANDed with `glob_ie`, using the values held just before that edge.
- R10: A mask bit of 0 blocks its source from `cpu_irq`, but the status bit is still recorded and still reads back.
- R11: Reading with `reg_addr`=1 returns the status register, with source n in bit n and unused upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NSRC | Interrupt inputs, asynchronous to clk |
| glob_ie | input | 1 | Processor global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 mask, 1 status |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected register |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
Two functions can act on a status bit in the same cycle: a new set event from the synchronizer and a software clearing write. The bench raises a source and then times a clearing write to land in the exact cycle where the synchronized rising edge reaches the status logic. It does this once with the standard clear value and once with the inverted one. A behavioural reference model, updated every clock for both acknowledge rules, then has to agree that the bit is still pending. A mask write that coincides with a status change is also covered, by a long random stretch that compares both register readbacks and the request line every cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   typedef enum logic {
      SEL_MASK = 1'b0,
      SEL_STAT = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
   parameter int NSRC        = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_i,
   output logic [NSRC-1:0] lvl_o,
   output logic [NSRC-1:0] rise_o
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0][NSRC-1:0] stage_q;
   logic [NSRC-1:0]                  prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         prev_q  <= '0;
      end else begin
         stage_q[0] <= src_i;
         for (int k = 1; k < SYNC_STAGES; k++) begin
            stage_q[k] <= stage_q[k-1];
         end
         prev_q <= stage_q[LAST];
      end
   end

   assign lvl_o  = stage_q[LAST];
   assign rise_o = stage_q[LAST] & ~prev_q;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int              NSRC         = 32,
   parameter logic [NSRC-1:0] EDGE_SRC     = '1,
   parameter bit              ACK_ZERO_CLR = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] lvl_i,
   input  logic [NSRC-1:0] rise_i,
   input  logic            ack_wr_i,
   input  logic [NSRC-1:0] ack_data_i,
   output logic [NSRC-1:0] pend_o
);
   logic [NSRC-1:0] set_vec;
   logic [NSRC-1:0] ack_vec;

   assign set_vec = (EDGE_SRC & rise_i) | (~EDGE_SRC & lvl_i);

   generate
      if (ACK_ZERO_CLR) begin : g_ack_zero
         assign ack_vec = ack_wr_i ? ~ack_data_i : '0;
      end else begin : g_ack_one
         assign ack_vec = ack_wr_i ? ack_data_i : '0;
      end

      for (genvar i = 0; i < NSRC; i++) begin : g_bit
         logic bit_q;
         if (!EDGE_SRC[i] && !ACK_ZERO_CLR) begin : g_follow
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) bit_q <= 1'b0;
               else        bit_q <= set_vec[i];
            end
         end else begin : g_latch
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) bit_q <= 1'b0;
               else        bit_q <= set_vec[i] | (bit_q & ~ack_vec[i]);
            end
         end
         assign pend_o[i] = bit_q;
      end
   endgenerate
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  logic [NSRC-1:0] wdata_i,
   output logic [NSRC-1:0] mask_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_o <= '0;
      else if (wr_i) mask_o <= wdata_i;
   end
endmodule

// File: rtl/irq_req_out.sv
module irq_req_out #(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] pend_i,
   input  logic [NSRC-1:0] mask_i,
   input  logic            gie_i,
   output logic            irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= gie_i & (|(pend_i & mask_i));
   end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int              NSRC         = 32,
   parameter int              DW           = 32,
   parameter int              SYNC_STAGES  = 2,
   parameter logic [NSRC-1:0] EDGE_SRC     = 32'h0000_FFFF,
   parameter bit              ACK_ZERO_CLR = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] irq_src,
   input  logic            glob_ie,
   input  logic            reg_wr,
   input  logic            reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [DW-1:0]   reg_rdata,
   output logic            cpu_irq
);
   generate
      if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
         $error("NSRC must lie in 1..32");
      end
      if (DW < NSRC) begin : g_bad_dw
         $error("DW must be at least NSRC");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NSRC-1:0] lvl_w, rise_w, pend_w, mask_w;
   logic            wr_mask, wr_stat;

   assign wr_mask = reg_wr && (reg_sel_e'(reg_addr) == SEL_MASK);
   assign wr_stat = reg_wr && (reg_sel_e'(reg_addr) == SEL_STAT);

   irq_in_sync #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .src_i(irq_src),
      .lvl_o(lvl_w), .rise_o(rise_w));

   irq_pend_bank #(.NSRC(NSRC), .EDGE_SRC(EDGE_SRC), .ACK_ZERO_CLR(ACK_ZERO_CLR)) u_pend (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl_w), .rise_i(rise_w),
      .ack_wr_i(wr_stat), .ack_data_i(reg_wdata[NSRC-1:0]), .pend_o(pend_w));

   irq_mask_reg #(.NSRC(NSRC)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_mask),
      .wdata_i(reg_wdata[NSRC-1:0]), .mask_o(mask_w));

   irq_req_out #(.NSRC(NSRC)) u_req (
      .clk(clk), .rst_n(rst_n), .pend_i(pend_w), .mask_i(mask_w),
      .gie_i(glob_ie), .irq_o(cpu_irq));

   always_comb begin
      reg_rdata = '0;
      reg_rdata[NSRC-1:0] = (reg_sel_e'(reg_addr) == SEL_STAT) ? pend_w : mask_w;
   end
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
   parameter int              NSRC         = 32,
   parameter int              DW           = 32,
   parameter logic [NSRC-1:0] EDGE_SRC     = '1,
   parameter bit              ACK_ZERO_CLR = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_wr,
   input logic            reg_addr,
   input logic [DW-1:0]   reg_wdata,
   input logic            glob_ie,
   input logic            cpu_irq,
   input logic [NSRC-1:0] mask_q,
   input logic [NSRC-1:0] pend_q
);
   localparam logic CLR_VAL = ACK_ZERO_CLR ? 1'b0 : 1'b1;

   p_reset_zero_r1: assert property (@(posedge clk)
      !rst_n |=> (cpu_irq == 1'b0 && mask_q == '0 && pend_q == '0));

   p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_addr) |=> (mask_q == $past(reg_wdata[NSRC-1:0])));

   // R9 and R10: the request follows pending AND enabled AND global enable
   p_req_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (cpu_irq == $past(glob_ie && (|(pend_q & mask_q)))));

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_hold
         if (EDGE_SRC[i] || ACK_ZERO_CLR) begin : g_chk
            // R3, R6, R7: a latched bit falls only under a clearing write
            p_hold_until_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
               (pend_q[i] && !(reg_wr && reg_addr && reg_wdata[i] == CLR_VAL))
               |=> pend_q[i]);
         end
      end
   endgenerate
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(
   .NSRC(NSRC), .DW(DW), .EDGE_SRC(EDGE_SRC), .ACK_ZERO_CLR(ACK_ZERO_CLR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .glob_ie(glob_ie), .cpu_irq(cpu_irq),
   .mask_q(mask_w), .pend_q(pend_w));

// File: tb/tb_irq_latch_ctrl.sv
`timescale 1ns/1ps
module tb_irq_latch_ctrl;
   localparam int          N    = 32;
   localparam logic [31:0] EDGE = 32'h0000_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] src = '0;
   logic        gie = 1'b0;
   logic        wr = 1'b0;
   logic        addr = 1'b0;
   logic [31:0] wd = '0;
   logic [31:0] rd0, rd1;
   logic        irq0, irq1;

   int    checks = 0;
   int    errors = 0;
   string tag = "R1";

   always #2.5 clk = ~clk;

   irq_latch_ctrl #(.EDGE_SRC(EDGE), .ACK_ZERO_CLR(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .irq_src(src), .glob_ie(gie), .reg_wr(wr),
      .reg_addr(addr), .reg_wdata(wd), .reg_rdata(rd0), .cpu_irq(irq0));

   irq_latch_ctrl #(.EDGE_SRC(EDGE), .ACK_ZERO_CLR(1'b1)) dut_alt (
      .clk(clk), .rst_n(rst_n), .irq_src(src), .glob_ie(gie), .reg_wr(wr),
      .reg_addr(addr), .reg_wdata(wd), .reg_rdata(rd1), .cpu_irq(irq1));

   task automatic chk(input string t, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h at %0t", t, what, act, exp, $time);
      end
   endtask

   // behavioural reference: input history plus per-rule pending words
   logic [N-1:0] h1 = '0, h2 = '0, h3 = '0, m_mask = '0;
   logic [N-1:0] m_std = '0, m_alt = '0;
   logic         m_irq_std = 1'b0, m_irq_alt = 1'b0;

   always @(posedge clk) begin : model
      logic [N-1:0] fresh, kill1, kill0, n_std, n_alt;
      if (!rst_n) begin
         h1 = '0; h2 = '0; h3 = '0; m_mask = '0;
         m_std = '0; m_alt = '0; m_irq_std = 1'b0; m_irq_alt = 1'b0;
      end else begin
         fresh = h2 & ~h3;
         kill1 = (wr && addr) ? wd : '0;
         kill0 = (wr && addr) ? ~wd : '0;
         n_std = (EDGE & (fresh | (m_std & ~kill1))) | (~EDGE & h2);
         n_alt = (EDGE & fresh) | (~EDGE & h2) | (m_alt & ~kill0);
         m_irq_std = gie && ((m_std & m_mask) != 0);
         m_irq_alt = gie && ((m_alt & m_mask) != 0);
         if (wr && !addr) m_mask = wd;
         m_std = n_std;
         m_alt = n_alt;
         h3 = h2; h2 = h1; h1 = src;
      end
      #1;
      chk("R9", "std cpu_irq", {31'd0, irq0}, {31'd0, m_irq_std});
      chk("R9", "alt cpu_irq", {31'd0, irq1}, {31'd0, m_irq_alt});
      chk(tag, addr ? "std status" : "std mask", rd0, addr ? m_std : m_mask);
      chk(tag, addr ? "alt status" : "alt mask", rd1, addr ? m_alt : m_mask);
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(input logic a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wd = d;
      @(negedge clk);
      wr = 1'b0; addr = 1'b1;
   endtask

   task automatic pulse(input logic [31:0] bits);
      @(negedge clk);
      src = src | bits;
      @(negedge clk);
      src = src & ~bits;
   endtask

   task automatic race(input logic [31:0] clear_word);
      @(negedge clk);
      src[5] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr = 1'b1; addr = 1'b1; wd = clear_word;
      @(negedge clk);
      wr = 1'b0; src[5] = 1'b0;
      idle(2);
   endtask

   initial begin : watchdog
      #750000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      idle(3);
      rst_n = 1'b1;
      idle(3);

      tag = "R2";
      reg_write(1'b0, 32'hA5A5_0F0F);
      addr = 1'b0; idle(2);
      reg_write(1'b0, 32'hFFFF_FFFF);

      tag = "R3 R11";
      addr = 1'b1; gie = 1'b1;
      pulse(32'h0000_0008); idle(5);
      pulse(32'h0000_8001); idle(5);

      tag = "R4 R6";
      reg_write(1'b1, 32'h0000_0000); idle(2);
      pulse(32'h0000_0028); idle(5);
      reg_write(1'b1, 32'h0000_0008); idle(3);

      tag = "R5 R7";
      src[20] = 1'b1; idle(4);
      reg_write(1'b1, 32'hFFFF_FFFF); idle(2);
      src[20] = 1'b0; idle(5);
      reg_write(1'b1, ~32'h0010_0000); idle(2);
      src[21] = 1'b1; idle(5);
      reg_write(1'b1, 32'h0000_0000); idle(2);
      src[21] = 1'b0; idle(5);
      reg_write(1'b1, 32'h0000_0000); idle(3);

      tag = "R8";
      reg_write(1'b1, 32'h0000_0020);
      reg_write(1'b1, ~32'h0000_0020);
      race(32'h0000_0020);
      @(negedge clk); chk("R8", "std bit5 after set/clear race", {31'd0, rd0[5]}, 32'd1);
      race(~32'h0000_0020);
      @(negedge clk); chk("R8", "alt bit5 after set/clear race", {31'd0, rd1[5]}, 32'd1);

      tag = "R10";
      reg_write(1'b0, 32'h0000_0000); idle(3);
      @(negedge clk); chk("R10", "std irq masked", {31'd0, irq0}, 32'd0);
      chk("R10", "std status kept", {31'd0, rd0[5]}, 32'd1);

      tag = "R9";
      reg_write(1'b0, 32'h0000_0020); idle(2);
      gie = 1'b0; idle(3);
      gie = 1'b1; idle(3);

      tag = "R11";
      for (int c = 0; c < 600; c++) begin
         @(negedge clk);
         src  = $urandom;
         wr   = ($urandom % 4) == 0;
         addr = $urandom % 2;
         wd   = $urandom;
         gie  = ($urandom % 8) != 0;
      end
      @(negedge clk);
      wr = 1'b0;
      idle(4);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule